// File: doc/BRIEF.md
# Indexed performance counter bank

This block holds a small set of wide event counters behind one narrow register port. Software first writes an index register to pick a counter; every later access to the count, condition, snapshot and threshold registers then reaches only that counter. Each counter watches one bit of a shared event vector, picked by a condition number in its configuration. It can also be limited to kernel-mode or user-mode cycles. A single global run bit starts and stops all counters at once.

A counter is wider than the 32-bit data path. A snapshot request copies the selected counter into a separate two-word holding register, so software can read a consistent value while counting goes on. Each counter also has a threshold and an interrupt enable. When an enabled counter sits at its threshold, an active flag is set and the interrupt line rises. Writing 1 to an active flag clears that flag and also clears the matching enable, so software re-arms explicitly. A read-only build word describes the bank.

Top module: `perf_ctr_bank`

## Requirements
- R1: Register map (4-bit address): 0 build, 1 control, 2 index, 3 count low, 4 count high, 5 snapshot low, 6 snapshot high, 7 configuration, 8 threshold low, 9 threshold high, 10 interrupt enable, 11 interrupt active. Reads of addresses 12 to 15 return 0 and writes to them change nothing. `rdata_o` takes the read value on the clock edge that samples `rd_en_i` and holds it otherwise.
- R2: Control bit 0 is the global run bit. While it is 0 no counter advances. Control bits 31:16 are stored and read back unchanged. Bit 1 (snapshot) always reads as 0.
- R3: Writing control with bit 1 set copies the selected counter's value from before that edge into the snapshot registers. Snapshot low holds bits 31:0 and snapshot high holds the upper bits, zero-extended. With an out-of-range index the copy is 0. Without such a write the snapshot does not change.
- R4: Configuration bits 7:0 hold the condition number. With condition 0 the counter never advances.
- R5: A counter with a nonzero condition c below the event width advances by exactly 1 in each cycle where the run bit is set, `ev_i[c]` is 1 and the mode filter passes. A condition at or above the event width never counts.
- R6: Configuration bit 8 limits counting to cycles with `priv_kernel_i`=1, and bit 9 limits it to cycles with `priv_kernel_i`=0. With neither bit set, counting happens in every mode. With both set, counting happens in either mode.
- R7: Index register bits 7:0 select the counter. With an index of at least the counter count, per-counter writes are ignored and per-counter reads return 0. The index register reads back as written.
- R8: A count-low write replaces bits 31:0 and a count-high write replaces the upper bits. A count write takes priority over an increment in the same cycle.
- R9: Bit i of the interrupt-enable register arms counter i. Active bit i is set on the edge after a cycle in which counter i is armed and equals its threshold.
- R10: Writing 1 to active bit i clears that active bit and enable bit i, and the clear beats a simultaneous set. Writing 0 bits changes nothing.
- R11: `irq_o` is 1 exactly when some bit is both active and enabled, and it updates on the same edge as those bits.
- R12: The build word reads bit 0 = 1 (counters present), bit 1 = 1 (interrupts present), bits 15:8 = counter count, and bits 19:16 = size field s, where the width is 32+16*s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| ev_i | input | NUM_EV | Event condition vector, sampled every cycle |
| priv_kernel_i | input | 1 | 1 in kernel mode, 0 in user mode |
| irq_o | output | 1 | Registered interrupt request |

## Verification
Every cycle, the assertions check the following: a counter moves by at most one, it stays still with condition 0 or with the run bit clear, the snapshot stays still without a request, an active flag only rises while armed, a write-1 clear leaves both flag and enable low, and the interrupt line follows the active-and-enabled bits. Other behaviour can only be shown by the bench's scenarios and its cycle model checking read data: which event bit a condition picks, the privilege filter, index decoding and out-of-range indexes, the two-word load and snapshot contents, write-over-increment priority, and the exact cycle a threshold hit is flagged.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  localparam int REG_AW = 4;
  localparam int COND_W = 8;

  typedef enum logic [REG_AW-1:0] {
    A_BUILD   = 4'd0,
    A_CTRL    = 4'd1,
    A_INDEX   = 4'd2,
    A_CNT_LO  = 4'd3,
    A_CNT_HI  = 4'd4,
    A_SNAP_LO = 4'd5,
    A_SNAP_HI = 4'd6,
    A_CFG     = 4'd7,
    A_THR_LO  = 4'd8,
    A_THR_HI  = 4'd9,
    A_IEN     = 4'd10,
    A_IACT    = 4'd11
  } reg_addr_e;

  // configuration word layout: [9] user only, [8] kernel only, [7:0] condition
  typedef struct packed {
    logic              user_only;
    logic              kern_only;
    logic [COND_W-1:0] cond;
  } cnt_cfg_t;
endpackage

// File: rtl/pcb_counter.sv
module pcb_counter
  import pcb_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int NUM_EV = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              run_i,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              kern_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic              wr_cfg_i,
  input  logic              wr_tlo_i,
  input  logic              wr_thi_i,
  input  logic [31:0]       wdata_i,
  output logic [CNT_W-1:0]  cnt_o,
  output cnt_cfg_t          cfg_o,
  output logic [CNT_W-1:0]  thr_o,
  output logic              hit_o
);
  localparam int HI_W = CNT_W - 32;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] thr_q;
  cnt_cfg_t         cfg_q;
  logic             ev_sel;
  logic             mode_ok;
  logic             inc;
  logic             wr_any;

  always_comb begin
    ev_sel = 1'b0;
    for (int e = 0; e < NUM_EV; e++) begin
      if (cfg_q.cond == COND_W'(e)) ev_sel = ev_i[e];
    end
  end

  assign mode_ok = (!cfg_q.kern_only && !cfg_q.user_only) ||
                   (cfg_q.kern_only && kern_i) ||
                   (cfg_q.user_only && !kern_i);
  assign inc     = run_i && (cfg_q.cond != '0) && ev_sel && mode_ok;
  assign wr_any  = wr_lo_i || wr_hi_i;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      thr_q <= '0;
      cfg_q <= '0;
    end else begin
      if (wr_lo_i)      cnt_q[31:0]       <= wdata_i;
      else if (wr_hi_i) cnt_q[CNT_W-1:32] <= wdata_i[HI_W-1:0];
      else if (inc)     cnt_q             <= cnt_q + 1'b1;
      if (wr_cfg_i)     cfg_q             <= cnt_cfg_t'(wdata_i[9:0]);
      if (wr_tlo_i)     thr_q[31:0]       <= wdata_i;
      if (wr_thi_i)     thr_q[CNT_W-1:32] <= wdata_i[HI_W-1:0];
    end
  end

  assign cnt_o = cnt_q;
  assign cfg_o = cfg_q;
  assign thr_o = thr_q;
  assign hit_o = (cnt_q == thr_q);

  // R5: a counter moves by zero or one per cycle unless loaded
  a_r5_step_one: assert property (@(posedge clk_i) disable iff (rst_i)
    !wr_any |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 1'b1));
  // R4: condition zero never counts
  a_r4_never_cond: assert property (@(posedge clk_i) disable iff (rst_i)
    (!wr_any && cfg_q.cond == '0) |=> cnt_q == $past(cnt_q));
  // R2: global run bit clear freezes the counter
  a_r2_run_gate: assert property (@(posedge clk_i) disable iff (rst_i)
    (!wr_any && !run_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pcb_irq.sv
module pcb_irq #(
  parameter int NUM_CNT = 4
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic [NUM_CNT-1:0] hit_i,
  input  logic               wr_en_i,
  input  logic               wr_act_i,
  input  logic [NUM_CNT-1:0] wbits_i,
  output logic [NUM_CNT-1:0] en_o,
  output logic [NUM_CNT-1:0] act_o,
  output logic               irq_o
);
  logic [NUM_CNT-1:0] en_q, act_q, en_d, act_d, set_v;
  logic               irq_q;

  assign set_v = en_q & hit_i;

  always_comb begin
    en_d  = en_q;
    act_d = act_q | set_v;
    if (wr_en_i) en_d = wbits_i;
    if (wr_act_i) begin
      act_d = act_d & ~wbits_i;
      en_d  = en_q & ~wbits_i;
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      en_q  <= '0;
      act_q <= '0;
      irq_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      act_q <= act_d;
      irq_q <= |(act_d & en_d);
    end
  end

  assign en_o  = en_q;
  assign act_o = act_q;
  assign irq_o = irq_q;

  // R9: a flag rises only while its counter was armed
  a_r9_set_needs_en: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_q & ~$past(act_q) & ~$past(en_q)) == '0);
  // R10: write-one clear drops both flag and enable
  a_r10_w1c_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_act_i |=> ((act_q | en_q) & $past(wbits_i)) == '0);
  // R11: line follows active-and-enabled bits
  a_r11_irq_tracks: assert property (@(posedge clk_i) disable iff (rst_i)
    irq_q == |(act_q & en_q));
endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
  import pcb_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int CNT_W   = 48,
  parameter int NUM_EV  = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [3:0]        addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_EV-1:0] ev_i,
  input  logic              priv_kernel_i,
  output logic              irq_o
);
  localparam int IDX_W  = $clog2(NUM_CNT);
  localparam int HI_W   = CNT_W - 32;
  localparam int SIZE_F = (CNT_W - 32) / 16;

  logic [7:0]       idx_q;
  logic             idx_ok;
  logic [IDX_W-1:0] sel;
  logic             run_q;
  logic [15:0]      upper_q;
  logic [CNT_W-1:0] snap_q;
  logic             snap_req;
  logic [31:0]      rd_d, rdata_q;

  logic [CNT_W-1:0]   cnt_a [NUM_CNT];
  logic [CNT_W-1:0]   thr_a [NUM_CNT];
  cnt_cfg_t           cfg_a [NUM_CNT];
  logic [NUM_CNT-1:0] hit_v, en_v, act_v;
  logic [CNT_W-1:0]   cnt_sel, thr_sel;
  cnt_cfg_t           cfg_sel;

  assign idx_ok   = idx_q < 8'(NUM_CNT);
  assign sel      = idx_q[IDX_W-1:0];
  assign snap_req = wr_en_i && (addr_i == A_CTRL) && wdata_i[1];

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    logic pick;
    assign pick = wr_en_i && idx_ok && (sel == IDX_W'(i));
    pcb_counter #(.CNT_W(CNT_W), .NUM_EV(NUM_EV)) u_cnt (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .run_i    (run_q),
      .ev_i     (ev_i),
      .kern_i   (priv_kernel_i),
      .wr_lo_i  (pick && addr_i == A_CNT_LO),
      .wr_hi_i  (pick && addr_i == A_CNT_HI),
      .wr_cfg_i (pick && addr_i == A_CFG),
      .wr_tlo_i (pick && addr_i == A_THR_LO),
      .wr_thi_i (pick && addr_i == A_THR_HI),
      .wdata_i  (wdata_i),
      .cnt_o    (cnt_a[i]),
      .cfg_o    (cfg_a[i]),
      .thr_o    (thr_a[i]),
      .hit_o    (hit_v[i])
    );
  end

  pcb_irq #(.NUM_CNT(NUM_CNT)) u_irq (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .hit_i    (hit_v),
    .wr_en_i  (wr_en_i && addr_i == A_IEN),
    .wr_act_i (wr_en_i && addr_i == A_IACT),
    .wbits_i  (wdata_i[NUM_CNT-1:0]),
    .en_o     (en_v),
    .act_o    (act_v),
    .irq_o    (irq_o)
  );

  always_comb begin
    cnt_sel = idx_ok ? cnt_a[sel] : '0;
    thr_sel = idx_ok ? thr_a[sel] : '0;
    cfg_sel = idx_ok ? cfg_a[sel] : '0;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      idx_q   <= '0;
      run_q   <= 1'b0;
      upper_q <= '0;
      snap_q  <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_INDEX) idx_q <= wdata_i[7:0];
      if (addr_i == A_CTRL) begin
        run_q   <= wdata_i[0];
        upper_q <= wdata_i[31:16];
      end
      if (snap_req) snap_q <= cnt_sel;
    end
  end

  always_comb begin
    rd_d = '0;
    case (addr_i)
      A_BUILD: begin
        rd_d[0]     = 1'b1;
        rd_d[1]     = 1'b1;
        rd_d[15:8]  = 8'(NUM_CNT);
        rd_d[19:16] = 4'(SIZE_F);
      end
      A_CTRL:    begin rd_d[31:16] = upper_q; rd_d[0] = run_q; end
      A_INDEX:   rd_d[7:0] = idx_q;
      A_CNT_LO:  rd_d = cnt_sel[31:0];
      A_CNT_HI:  rd_d[HI_W-1:0] = cnt_sel[CNT_W-1:32];
      A_SNAP_LO: rd_d = snap_q[31:0];
      A_SNAP_HI: rd_d[HI_W-1:0] = snap_q[CNT_W-1:32];
      A_CFG:     rd_d[9:0] = cfg_sel;
      A_THR_LO:  rd_d = thr_sel[31:0];
      A_THR_HI:  rd_d[HI_W-1:0] = thr_sel[CNT_W-1:32];
      A_IEN:     rd_d[NUM_CNT-1:0] = en_v;
      A_IACT:    rd_d[NUM_CNT-1:0] = act_v;
      default:   rd_d = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i)        rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;

  // R3: snapshot holds unless requested
  a_r3_snap_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !snap_req |=> $stable(snap_q));
  // R1: read data holds without a read strobe
  a_r1_rdata_hold: assert property (@(posedge clk_i) disable iff (rst_i)
    !rd_en_i |=> $stable(rdata_q));
endmodule

// File: tb/test_perf_ctr_bank.sv
`timescale 1ns/1ps
module test_perf_ctr_bank;
  localparam int NC = 4;
  localparam int NE = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, priv = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NE-1:0] ev = '0;
  logic        irq;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  string cur_tag = "R1";
  logic [NE-1:0] ev_cur = '0;
  bit kern_cur = 1'b0;

  // reference model state
  logic [47:0] m_cnt [NC];
  logic [47:0] m_thr [NC];
  logic [7:0]  m_cond [NC];
  bit          m_k [NC];
  bit          m_u [NC];
  logic [NC-1:0] m_en, m_act;
  bit          m_run;
  logic [15:0] m_up;
  logic [7:0]  m_idx;
  logic [47:0] m_snap;

  always #2 clk = ~clk;

  perf_ctr_bank #(.NUM_CNT(NC), .CNT_W(48), .NUM_EV(NE)) i_perf_ctr_bank (
    .clk_i(clk), .rst_i(rst), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .ev_i(ev),
    .priv_kernel_i(priv), .irq_o(irq));

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] model_read(logic [3:0] a);
    logic [31:0] r = '0;
    bit ok = (m_idx < NC);
    int s = int'(m_idx[1:0]);
    case (a)
      4'd0: begin r[0] = 1; r[1] = 1; r[15:8] = NC; r[19:16] = 1; end
      4'd1: begin r[31:16] = m_up; r[0] = m_run; end
      4'd2: r[7:0] = m_idx;
      4'd3: if (ok) r = m_cnt[s][31:0];
      4'd4: if (ok) r[15:0] = m_cnt[s][47:32];
      4'd5: r = m_snap[31:0];
      4'd6: r[15:0] = m_snap[47:32];
      4'd7: if (ok) begin r[7:0] = m_cond[s]; r[8] = m_k[s]; r[9] = m_u[s]; end
      4'd8: if (ok) r = m_thr[s][31:0];
      4'd9: if (ok) r[15:0] = m_thr[s][47:32];
      4'd10: r[NC-1:0] = m_en;
      4'd11: r[NC-1:0] = m_act;
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic step(bit we, bit re, logic [3:0] a, logic [31:0] d);
    logic [31:0] exp_rd;
    logic [47:0] n_cnt [NC];
    logic [NC-1:0] hit, n_en, n_act;
    bit ok;
    int s;
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = d; ev = ev_cur; priv = kern_cur;
    exp_rd = model_read(a);
    ok = (m_idx < NC);
    s = int'(m_idx[1:0]);
    for (int i = 0; i < NC; i++) begin
      bit mode_ok = (!m_k[i] && !m_u[i]) || (m_k[i] && kern_cur) || (m_u[i] && !kern_cur);
      bit inc = m_run && m_cond[i] != 0 && m_cond[i] < NE && ev_cur[m_cond[i][3:0]] && mode_ok;
      bit pk = we && ok && (s == i);
      hit[i] = m_en[i] && (m_cnt[i] == m_thr[i]);
      n_cnt[i] = m_cnt[i];
      if (pk && a == 4'd3)      n_cnt[i][31:0]  = d;
      else if (pk && a == 4'd4) n_cnt[i][47:32] = d[15:0];
      else if (inc)             n_cnt[i]        = m_cnt[i] + 1;
      if (pk && a == 4'd7) begin m_cond[i] = d[7:0]; m_k[i] = d[8]; m_u[i] = d[9]; end
      if (pk && a == 4'd8) m_thr[i][31:0]  = d;
      if (pk && a == 4'd9) m_thr[i][47:32] = d[15:0];
    end
    n_act = m_act | hit;
    n_en  = m_en;
    if (we && a == 4'd10) n_en = d[NC-1:0];
    if (we && a == 4'd11) begin n_act = n_act & ~d[NC-1:0]; n_en = m_en & ~d[NC-1:0]; end
    if (we && a == 4'd1) begin
      if (d[1]) m_snap = ok ? m_cnt[s] : '0;
      m_run = d[0]; m_up = d[31:16];
    end
    if (we && a == 4'd2) m_idx = d[7:0];
    @(posedge clk); #1;
    for (int i = 0; i < NC; i++) m_cnt[i] = n_cnt[i];
    m_en = n_en; m_act = n_act;
    if (re) check(cur_tag, rdata, exp_rd);
    check("R11 irq", {31'b0, irq}, {31'b0, |(m_act & m_en)});
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d); step(1, 0, a, d); endtask
  task automatic rd(logic [3:0] a);                 step(0, 1, a, '0); endtask
  task automatic idle(int n); for (int k = 0; k < n; k++) step(0, 0, 4'd0, '0); endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < NC; i++) begin
      m_cnt[i] = '0; m_thr[i] = '0; m_cond[i] = '0; m_k[i] = 0; m_u[i] = 0;
    end
    m_en = '0; m_act = '0; m_run = 0; m_up = '0; m_idx = '0; m_snap = '0;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // reset state
    cur_tag = "R12 build"; rd(4'd0);
    check("R12 build literal", rdata, 32'h0001_0403);
    cur_tag = "R2 ctrl reset"; rd(4'd1);
    cur_tag = "R1 unmapped"; wr(4'd13, 32'hFFFF_FFFF); rd(4'd13);

    // R5: condition 3 counts while event 3 high
    ev_cur = 16'h0008;
    wr(4'd7, 32'd3);
    wr(4'd1, 32'hABCD_0003);
    idle(10);
    wr(4'd1, 32'hABCD_0000);
    cur_tag = "R5 count"; rd(4'd3);
    check("R5 count literal", rdata, 32'd11);
    cur_tag = "R2 upper keep"; rd(4'd1);
    check("R2 ctrl literal", rdata, 32'hABCD_0000);

    // R4: condition 0 on counter 1 never counts
    wr(4'd2, 32'd1); wr(4'd7, 32'd0);
    ev_cur = 16'hFFFF; wr(4'd1, 32'd1); idle(8);
    cur_tag = "R4 never"; rd(4'd3);
    check("R4 literal", rdata, 32'd0);

    // R6: kernel-only filter on counter 2
    wr(4'd2, 32'd2); wr(4'd7, 32'h105);
    kern_cur = 0; idle(5);
    cur_tag = "R6 user blocked"; rd(4'd3);
    kern_cur = 1; idle(5);
    cur_tag = "R6 kernel counts"; rd(4'd3);
    wr(4'd7, 32'h205); idle(4);
    cur_tag = "R6 user only"; rd(4'd3);

    // R8: load high/low and write over increment
    wr(4'd4, 32'h0000_1234);
    cur_tag = "R8 load hi"; rd(4'd4);
    kern_cur = 0;
    wr(4'd3, 32'hFFFF_FFF0);
    cur_tag = "R8 write wins"; rd(4'd3);

    // R3: snapshot while counting continues
    wr(4'd1, 32'h3); idle(3);
    cur_tag = "R3 snap lo"; rd(4'd5);
    cur_tag = "R3 snap hi"; rd(4'd6);
    idle(20);
    cur_tag = "R3 carry into hi"; rd(4'd4);
    cur_tag = "R3 snap stable"; rd(4'd5);

    // R7: out-of-range index
    wr(4'd2, 32'd7); wr(4'd3, 32'h5555); wr(4'd7, 32'd4);
    cur_tag = "R7 bad read"; rd(4'd3);
    check("R7 literal", rdata, 32'd0);
    cur_tag = "R7 index readback"; rd(4'd2);

    // R9/R10/R11: threshold interrupt on counter 0
    wr(4'd1, 32'd0); wr(4'd2, 32'd0);
    wr(4'd7, 32'd3); ev_cur = 16'h0008;
    wr(4'd3, 32'd100); wr(4'd4, 32'd0);
    wr(4'd8, 32'd105); wr(4'd9, 32'd0);
    wr(4'd10, 32'd1);
    wr(4'd1, 32'd1); idle(10);
    check("R11 irq high", {31'b0, irq}, 32'd1);
    cur_tag = "R9 active"; rd(4'd11);
    check("R9 literal", rdata, 32'd1);
    wr(4'd11, 32'd0);
    cur_tag = "R10 zero no effect"; rd(4'd11);
    wr(4'd11, 32'd1);
    check("R10 irq low", {31'b0, irq}, 32'd0);
    cur_tag = "R10 enable cleared"; rd(4'd10);
    check("R10 literal", rdata, 32'd0);

    // R2: run bit off freezes
    wr(4'd1, 32'd0); idle(5);
    cur_tag = "R2 frozen"; rd(4'd3);

    // random phase
    cur_tag = "R5 random";
    for (int n = 0; n < 4000; n++) begin
      int op = $urandom % 8;
      logic [3:0] a = 4'($urandom % 13);
      logic [31:0] d = $urandom;
      ev_cur = 16'($urandom);
      kern_cur = $urandom % 2;
      if (a == 4'd2) d = $urandom % 6;
      if (a == 4'd7) d = {22'b0, 2'($urandom), 8'($urandom % 20)};
      if (a == 4'd1 && ($urandom % 4 != 0)) d[0] = 1'b1;
      if (a == 4'd8) d = $urandom % 64;
      if (a == 4'd9) d = 0;
      if (op < 3) step(1, 0, a, d);
      else if (op < 6) step(0, 1, a, '0);
      else step(0, 0, 4'd0, '0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule